// File: doc/BRIEF.md
# DMA Channel Error Status Bank

This block keeps one sticky error flag per DMA channel. The transfer engine drives a one-cycle pulse on a channel's set input when that channel hits an error. The flag then stays up until software clears it. Software has two ways to clear flags. It can write a bitmap in which each 1 clears the matching channel. It can also write a channel number, or an all-channels flag, to a dedicated clear register.

An enable register decides which flags reach the per-channel interrupt outputs. Reads of the status register always return the raw flags, whatever the enable mask holds. A combined pending output rises whenever any flag is set. Raising a flag has no effect on any channel's normal completion signalling, which lives outside this block.

The register port is a plain single-cycle write strobe plus a read strobe with registered read data. Offsets: 0 is status, 1 is enable and 2 is single clear.

Top module: `dma_err_bank`

## Requirements
- R1: After reset, every status and enable bit is 0, `rdata` is 0, `err_irq` is all zeros and `err_any` is 0.
- R2: A pulse on `err_set[k]` sets status bit k at the next rising edge. The bit then stays set until a software clear removes it.
- R3: A write to offset 0 clears each status bit whose position in `wdata` holds 1. Bits whose position holds 0 keep their value.
- R4: A write to offset 2 with `wdata[6]`=0 clears only the status bit of the channel numbered by `wdata[3:0]`.
- R5: A write to offset 2 with `wdata[6]`=1 clears every status bit, whatever `wdata[3:0]` holds.
- R6: If an engine set and a software clear (from either path) hit the same bit in the same cycle, the bit ends up set.
- R7: The enable register at offset 1 takes `wdata[15:0]` on a write and returns that value on a read.
- R8: `err_irq[k]` is high exactly when status bit k and enable bit k are both 1.
- R9: A read of offset 0 returns the raw status in bits 15:0, whatever the enable mask holds. `err_any` is the OR of all raw status bits.
- R10: Reads of offset 2 and of unmapped offsets (3 to 15) return 0. Writes to unmapped offsets change neither status nor enable.
- R11: `rdata` updates at the rising edge that samples `rd_en` high, showing the state just before that edge. It holds its value in every cycle without a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 4 | Register offset |
| wdata | input | 32 | Write data |
| err_set | input | 16 | Per-channel error pulses from the engine |
| rdata | output | 32 | Registered read data |
| err_irq | output | 16 | Enabled per-channel error interrupts |
| err_any | output | 1 | OR of all raw error flags |

## Verification
Set pulses and register writes both land at the first rising edge after they are driven. From then on, `err_any` and `err_irq` show the new state with no further delay. Read data appears one edge after `rd_en` is sampled and holds the pre-edge state. The bench therefore drives every input on the falling edge and checks outputs on the following falling edge. Its monitor takes the queued expected read value one half-cycle after the edge that sampled `rd_en`, and the expected value is computed from the bench's model as it stood when the read was issued.

// File: rtl/dma_err_pkg.sv
package dma_err_pkg;

    // Register offsets on the bus
    localparam int unsigned OFS_STATUS = 0;
    localparam int unsigned OFS_ENABLE = 1;
    localparam int unsigned OFS_CLEAR  = 2;

    // Position of the clear-everything flag in a clear-register write
    localparam int unsigned CLR_ALL_POS = 6;

    // Kind of bus write being decoded in a cycle
    typedef enum logic [1:0] {
        WR_NONE  = 2'd0,
        WR_W1C   = 2'd1,
        WR_ENA   = 2'd2,
        WR_CHCLR = 2'd3
    } wr_kind_e;

endpackage

// File: rtl/err_clr_decode.sv
module err_clr_decode
    import dma_err_pkg::*;
#(
    parameter int unsigned NUM_CH = 16,
    parameter int unsigned ADDR_W = 4,
    parameter int unsigned DATA_W = 32
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [NUM_CH-1:0] clr_mask,
    output logic              en_we,
    output logic [NUM_CH-1:0] en_val
);

    localparam int unsigned CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

    wr_kind_e          kind;
    logic [CH_W-1:0]   ch_sel;
    logic              clr_all;

    // Classify the write by offset
    always_comb begin
        kind = WR_NONE;
        if (wr_en) begin
            if (addr == ADDR_W'(OFS_STATUS)) begin
                kind = WR_W1C;
            end else if (addr == ADDR_W'(OFS_ENABLE)) begin
                kind = WR_ENA;
            end else if (addr == ADDR_W'(OFS_CLEAR)) begin
                kind = WR_CHCLR;
            end
        end
    end

    assign ch_sel  = wdata[CH_W-1:0];
    assign clr_all = wdata[CLR_ALL_POS];

    // Build the clear mask and the enable load from the write kind
    always_comb begin
        clr_mask = '0;
        en_we    = 1'b0;
        en_val   = wdata[NUM_CH-1:0];
        unique case (kind)
            WR_W1C: begin
                clr_mask = wdata[NUM_CH-1:0];
            end
            WR_ENA: begin
                en_we = 1'b1;
            end
            WR_CHCLR: begin
                if (clr_all) begin
                    clr_mask = '1;
                end else if (int'(ch_sel) < int'(NUM_CH)) begin
                    clr_mask[ch_sel] = 1'b1;
                end
            end
            default: begin
                clr_mask = '0;
            end
        endcase
    end

    // A numbered clear touches at most one channel (R4)
    always_comb begin
        if (kind == WR_CHCLR && !clr_all) begin
            p_single_bit_r4: assert ($countones(clr_mask) <= 1)
                else $error("numbered clear hit more than one channel");
        end
    end

    generate
        if (DATA_W > NUM_CH && DATA_W > CLR_ALL_POS + 1) begin : g_unused
            logic unused_hi_bits;
            assign unused_hi_bits = ^wdata[DATA_W-1:NUM_CH];
        end
    endgenerate

endmodule

// File: rtl/err_status_bank.sv
module err_status_bank #(
    parameter int unsigned NUM_CH = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] set_vec,
    input  logic [NUM_CH-1:0] clr_vec,
    output logic [NUM_CH-1:0] status
);

    typedef struct packed {
        logic [NUM_CH-1:0] bits;
    } st_t;

    st_t st_d, st_q;

    // Per channel: clear first, then set, so the set wins a collision
    always_comb begin
        st_d = st_q;
        for (int i = 0; i < int'(NUM_CH); i++) begin
            if (clr_vec[i]) st_d.bits[i] = 1'b0;
            if (set_vec[i]) st_d.bits[i] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign status = st_q.bits;

    // Every pulsed channel is flagged after the edge, clear or not (R2, R6)
    p_set_lands_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (set_vec != '0) |=> ((status & $past(set_vec)) == $past(set_vec)))
        else $error("error pulse lost");

    // A bit only rises because of a set pulse (R2)
    p_rise_needs_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (status != '1) |=> ((status & ~$past(status) & ~$past(set_vec)) == '0))
        else $error("status bit rose with no set pulse");

    // A bit only falls because a clear reached it (R3)
    p_fall_needs_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (status != '0) |=> (($past(status) & ~status & ~$past(clr_vec)) == '0))
        else $error("status bit fell with no clear");

endmodule

// File: rtl/err_irq_gate.sv
module err_irq_gate #(
    parameter int unsigned NUM_CH = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_we,
    input  logic [NUM_CH-1:0] en_val,
    input  logic [NUM_CH-1:0] status,
    output logic [NUM_CH-1:0] en_mask,
    output logic [NUM_CH-1:0] irq
);

    typedef struct packed {
        logic [NUM_CH-1:0] mask;
    } en_t;

    en_t en_d, en_q;

    always_comb begin
        en_d = en_q;
        if (en_we) en_d.mask = en_val;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q <= '0;
        end else begin
            en_q <= en_d;
        end
    end

    assign en_mask = en_q.mask;

    // Gate each flag with its enable
    generate
        for (genvar g = 0; g < int'(NUM_CH); g++) begin : g_gate
            assign irq[g] = status[g] & en_q.mask[g];
        end
    endgenerate

    // The enable register loads on a write (R7)
    p_enable_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
        en_we |=> (en_mask == $past(en_val)))
        else $error("enable register did not load");

    // The enable register holds without a write (R7)
    p_enable_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !en_we |=> $stable(en_mask))
        else $error("enable register changed without a write");

endmodule

// File: rtl/dma_err_bank.sv
module dma_err_bank
    import dma_err_pkg::*;
#(
    parameter int unsigned NUM_CH = 16,
    parameter int unsigned ADDR_W = 4,
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [NUM_CH-1:0] err_set,
    output logic [DATA_W-1:0] rdata,
    output logic [NUM_CH-1:0] err_irq,
    output logic              err_any
);

    localparam int unsigned CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

    typedef struct packed {
        logic [DATA_W-1:0] data;
    } rd_t;

    logic [NUM_CH-1:0] clr_mask;
    logic              en_we;
    logic [NUM_CH-1:0] en_val;
    logic [NUM_CH-1:0] status;
    logic [NUM_CH-1:0] en_mask;

    rd_t rd_d, rd_q;

    err_clr_decode #(
        .NUM_CH (NUM_CH),
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_decode (
        .wr_en    (wr_en),
        .addr     (addr),
        .wdata    (wdata),
        .clr_mask (clr_mask),
        .en_we    (en_we),
        .en_val   (en_val)
    );

    err_status_bank #(
        .NUM_CH (NUM_CH)
    ) u_status (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_vec (err_set),
        .clr_vec (clr_mask),
        .status  (status)
    );

    err_irq_gate #(
        .NUM_CH (NUM_CH)
    ) u_gate (
        .clk     (clk),
        .rst_n   (rst_n),
        .en_we   (en_we),
        .en_val  (en_val),
        .status  (status),
        .en_mask (en_mask),
        .irq     (err_irq)
    );

    // Read mux, captured only on a read strobe
    always_comb begin
        rd_d = rd_q;
        if (rd_en) begin
            rd_d.data = '0;
            if (addr == ADDR_W'(OFS_STATUS)) begin
                rd_d.data[NUM_CH-1:0] = status;
            end else if (addr == ADDR_W'(OFS_ENABLE)) begin
                rd_d.data[NUM_CH-1:0] = en_mask;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else begin
            rd_q <= rd_d;
        end
    end

    assign rdata   = rd_q.data;
    assign err_any = |status;

    // Read data holds between reads (R11)
    p_rdata_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rdata))
        else $error("read data moved without a read");

    // The pending flag only rises after an engine pulse (R9)
    p_any_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_any) |-> $past(err_set != '0))
        else $error("pending flag rose with no error pulse");

    // A numbered clear with no competing set leaves that channel clear (R4)
    p_numbered_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_W'(OFS_CLEAR) && !wdata[CLR_ALL_POS]
         && int'(wdata[CH_W-1:0]) < int'(NUM_CH)
         && !err_set[wdata[CH_W-1:0]])
        |=> !status[$past(wdata[CH_W-1:0])])
        else $error("numbered clear did not clear its channel");

endmodule

// File: tb/dma_err_bank_test.sv
module dma_err_bank_test;

    logic        clk;
    logic        rst_n;
    logic        wr_en;
    logic        rd_en;
    logic [3:0]  addr;
    logic [31:0] wdata;
    logic [15:0] err_set;
    logic [31:0] rdata;
    logic [15:0] err_irq;
    logic        err_any;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 0;

    logic [15:0] m_st;
    logic [15:0] m_en;
    logic [31:0] last_rd;

    logic [31:0] exp_q[$];
    string       tag_q[$];

    dma_err_bank uut (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .rd_en   (rd_en),
        .addr    (addr),
        .wdata   (wdata),
        .err_set (err_set),
        .rdata   (rdata),
        .err_irq (err_irq),
        .err_any (err_any)
    );

    initial clk = 1'b0;
    always #5 clk = ~clk;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Model of a bus write plus engine pulses in one cycle
    task automatic model_cycle(input bit wr, input logic [3:0] a, input logic [31:0] d, input logic [15:0] s);
        logic [15:0] clr;
        clr = '0;
        if (wr) begin
            if (a == 4'd0) clr = d[15:0];
            else if (a == 4'd2) begin
                if (d[6]) clr = '1;
                else clr[d[3:0]] = 1'b1;
            end
            else if (a == 4'd1) m_en = d[15:0];
        end
        m_st = (m_st & ~clr) | s;
    endtask

    // Driver: one cycle, starting and ending on a falling edge
    task automatic drive(input bit wr, input logic [3:0] a, input logic [31:0] d, input logic [15:0] s);
        wr_en = wr; addr = a; wdata = d; err_set = s;
        @(negedge clk);
        wr_en = 1'b0; err_set = '0; wdata = '0;
        model_cycle(wr, a, d, s);
    endtask

    task automatic bus_read(input logic [3:0] a, input string tag);
        logic [31:0] e;
        e = '0;
        if (a == 4'd0) e[15:0] = m_st;
        else if (a == 4'd1) e[15:0] = m_en;
        exp_q.push_back(e);
        tag_q.push_back(tag);
        last_rd = e;
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic check_outs(input string tag);
        chk(err_irq === (m_st & m_en), {tag, " irq (R8)"}, {16'd0, err_irq}, {16'd0, m_st & m_en});
        chk(err_any === (|m_st), {tag, " any (R9)"}, {31'd0, err_any}, {31'd0, |m_st});
    endtask

    // Monitor: pops the expected read value after the sampling edge
    initial begin
        forever begin
            @(posedge clk);
            if (rd_en) begin
                @(negedge clk);
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R11 unexpected read", rdata, '0);
                end else begin
                    logic [31:0] e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    chk(rdata === e, t, rdata, e);
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            chk(1'b0, "watchdog", '0, '0);
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; addr = '0; wdata = '0; err_set = '0;
        m_st = '0; m_en = '0; last_rd = '0;
        repeat (3) @(negedge clk);
        chk(rdata === 32'd0, "R1 rdata reset", rdata, 32'd0);
        chk(err_irq === 16'd0, "R1 irq reset", {16'd0, err_irq}, 32'd0);
        chk(err_any === 1'b0, "R1 any reset", {31'd0, err_any}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        bus_read(4'd0, "R1 status after reset");
        bus_read(4'd1, "R1 enable after reset");

        // R2: set channels 3 and 10; enable still zero so no irq
        drive(1'b0, 4'd0, '0, 16'h0408);
        check_outs("R2 after set");
        bus_read(4'd0, "R2/R9 raw status with enables off");
        drive(1'b0, 4'd0, '0, 16'h0000);
        bus_read(4'd0, "R2 status sticks");

        // R7/R8: enable channel 3 only
        drive(1'b1, 4'd1, 32'hFFFF_0008, '0);
        bus_read(4'd1, "R7 enable readback");
        check_outs("R8 one enabled");

        // R3: clear channel 10 by bitmap, zeros leave channel 3
        drive(1'b1, 4'd0, 32'h0000_0401, '0);
        bus_read(4'd0, "R3 bitmap clear");
        check_outs("R3 after clear");

        // R4: numbered clear of channel 5
        drive(1'b0, 4'd0, '0, 16'hF0F0);
        drive(1'b1, 4'd2, 32'h0000_0005, '0);
        bus_read(4'd0, "R4 numbered clear ch5");
        drive(1'b1, 4'd2, 32'h0000_000F, '0);
        bus_read(4'd0, "R4 numbered clear ch15");

        // R10: unmapped and clear-register reads; unmapped write ignored
        bus_read(4'd2, "R10 clear reg reads zero");
        bus_read(4'd3, "R10 unmapped read zero");
        drive(1'b1, 4'd5, 32'hFFFF_FFFF, '0);
        bus_read(4'd0, "R10 status after unmapped write");
        bus_read(4'd1, "R10 enable after unmapped write");

        // R11: read data holds while status changes without reads
        drive(1'b0, 4'd0, '0, 16'h0001);
        drive(1'b0, 4'd0, '0, '0);
        chk(rdata === last_rd, "R11 rdata holds", rdata, last_rd);

        // R5: clear-all flag with a channel field present
        drive(1'b1, 4'd2, 32'h0000_0042, '0);
        bus_read(4'd0, "R5 clear all");
        check_outs("R5 after clear all");

        // R6: set wins over bitmap clear and over numbered clear
        drive(1'b1, 4'd0, 32'h0000_0080, 16'h0080);
        bus_read(4'd0, "R6 set beats bitmap clear");
        drive(1'b1, 4'd2, 32'h0000_0009, 16'h0200);
        bus_read(4'd0, "R6 set beats numbered clear");
        drive(1'b1, 4'd2, 32'h0000_0040, 16'h8001);
        bus_read(4'd0, "R6 set beats clear all");

        // R8: full enable, boundary channels
        drive(1'b1, 4'd1, 32'h0000_FFFF, '0);
        check_outs("R8 full enable");
        drive(1'b1, 4'd1, 32'h0000_8000, '0);
        check_outs("R8 top channel only");
        bus_read(4'd0, "R9 raw status under partial mask");

        repeat (3) @(negedge clk);
        chk(exp_q.size() == 0, "R11 all reads answered", exp_q.size(), 0);
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule